// File: doc/BRIEF.md
# Sampled Program Counter Debug Register Slave

This block is the external debug register window of one processor core, reached through a simple APB-style bus with zero wait states. Its main job is non-intrusive profiling. An external agent reads the low word of the sampled program counter. That same read freezes the core's context ID, its virtualization context (security state, exception level, register width and VMID) and the upper program counter bits into shadow registers. Those shadow registers can then be read at leisure, and they stay coherent with the low word that was returned.

The window also holds the register-access controls that a debugger needs before it may trust the sample:
- an OS lock;
- a power control register, whose power-up request bit drives a request line to the power controller;
- a power status register, which reports synchronized power-good and the double-lock flag;
- two identification registers, which give the implemented sampling level and the program counter offset convention. Both values are fixed at build time by parameters.

While the core is unpowered, double-locked or OS-locked, the sampling registers refuse access with a slave error. The power, status and identification registers stay reachable throughout, so software can always request power and inspect why access is refused.

Top module: `pcsDbgTop`

## Requirements
- R1: After reset the power control register reads 0, the power-up request output is 0, and the OS lock is set.
- R2: A write of zero to the OS lock register (offset 0x300) clears the lock, and a write of any nonzero value sets it. While the lock is set, reads of offsets 0x0A0, 0x0A4, 0x0A8 and 0x0AC return 0 with a slave error. The OS lock register itself reads 0.
- R3: A granted read of offset 0x0A0 returns the live PC bits 31:0. The same read captures the context ID, the virtual context and PC bits 63:32. Later reads of 0x0A4, 0x0A8 and 0x0AC return the captured values even after the core inputs change.
- R4: When the profiling-prohibit input is high, a granted read of 0x0A0 returns 0xFFFFFFFF without a slave error. The captured companion values are left unchanged.
- R5: The virtual context word at 0x0A8 has the following layout: bit 31 is non-secure, bit 30 is EL2, bit 29 is EL3, bit 28 is 64-bit width, bits 7:0 are the VMID, and all other bits are 0.
- R6: The power control register at 0x310 has two read/write bits: bit 3 is the power-up request and bit 0 is the no-powerdown request. All its other bits read 0. The power-up request output equals bit 3 from the cycle after the write.
- R7: A write to power control updates bit 0 only while the power status reports the core powered up. Otherwise bit 0 keeps its value, while bit 3 is always written.
- R8: Power status at 0x314 reports the power-good input in bit 0, delayed by a two-flop synchronizer so that it is first visible two clock edges after the input changes. Bit 6 reports the double-lock input, and all other bits are 0.
- R9: While the synchronized power-good is low or double lock is set, accesses to offsets 0x0A0 to 0x0AC and 0x300 return 0 with a slave error, and their writes are ignored. Accesses to 0x310, 0x314, 0xFC4 and 0xFC8 never raise a slave error.
- R10: Bits 3:0 of offset 0xFC8 hold the implementation level parameter, and bits 3:0 of 0xFC4 hold the offset mode parameter. Their upper bits are 0, and any unmapped offset reads 0 without a slave error.
- R11: When the implementation level is below 2 the context ID register reads 0. When it is below 3 the virtual context register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset in the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pslverr | output | 1 | Slave error, valid in the access phase |
| corePc | input | 64 | Live program counter of the core |
| coreCtxId | input | 32 | Live context ID |
| coreVmid | input | 8 | Live virtual machine ID |
| coreNs | input | 1 | Core in non-secure state |
| coreEl2 | input | 1 | Core at EL2 |
| coreEl3 | input | 1 | Core at EL3 |
| coreAa64 | input | 1 | Core running 64-bit |
| coreProhibit | input | 1 | Core in debug state or sampling prohibited |
| corePwrGood | input | 1 | Core power domain is up (asynchronous) |
| coreDblLock | input | 1 | OS double lock is set |
| pwrUpReq | output | 1 | Power-up request to the power controller |

## Verification
A wrong capture state is visible on the first read of a companion register after a low-word read. That read returns either the live inputs, which the bench has deliberately changed, or a stale value. A wrong grant state is visible in the same access phase: an error flag or a zero appears where data was expected, or the reverse. Synchronizer depth errors show as the power bit of the status register turning on one edge early or late. The bench watches a status read held open across those edges, so the failing cycle is identified exactly.

// File: rtl/pcsDbgPkg.sv
package pcsDbgPkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int VMID_W = 8;

  localparam logic [ADDR_W-1:0] OFF_PC_LO  = 12'h0A0;
  localparam logic [ADDR_W-1:0] OFF_CTX    = 12'h0A4;
  localparam logic [ADDR_W-1:0] OFF_VCTX   = 12'h0A8;
  localparam logic [ADDR_W-1:0] OFF_PC_HI  = 12'h0AC;
  localparam logic [ADDR_W-1:0] OFF_OSLOCK = 12'h300;
  localparam logic [ADDR_W-1:0] OFF_CTRL   = 12'h310;
  localparam logic [ADDR_W-1:0] OFF_STAT   = 12'h314;
  localparam logic [ADDR_W-1:0] OFF_ID1    = 12'hFC4;
  localparam logic [ADDR_W-1:0] OFF_ID     = 12'hFC8;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_PCLO, SEL_CTX, SEL_VCTX, SEL_PCHI,
    SEL_CTRL, SEL_STAT, SEL_ID1, SEL_ID
  } rdSel_e;

  typedef struct packed {
    logic   capture;
    logic   wrCtrl;
    logic   wrOsLock;
    rdSel_e rdSel;
  } strobe_t;
endpackage

// File: rtl/pcsDbgCtrl.sv
module pcsDbgCtrl
  import pcsDbgPkg::*;
(
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic              pwrOn,
  input  logic              dblLock,
  input  logic              osLocked,
  input  logic              coreProhibit,
  output strobe_t           stb,
  output logic              slverr
);
  logic   access;
  rdSel_e sel;
  logic   isOsLock;
  logic   isSample;
  logic   pwrBlocked;
  logic   sampleBlocked;

  assign access = psel && penable;

  always_comb begin
    sel      = SEL_NONE;
    isOsLock = 1'b0;
    case (paddr)
      OFF_PC_LO:  sel = SEL_PCLO;
      OFF_CTX:    sel = SEL_CTX;
      OFF_VCTX:   sel = SEL_VCTX;
      OFF_PC_HI:  sel = SEL_PCHI;
      OFF_CTRL:   sel = SEL_CTRL;
      OFF_STAT:   sel = SEL_STAT;
      OFF_ID1:    sel = SEL_ID1;
      OFF_ID:     sel = SEL_ID;
      OFF_OSLOCK: isOsLock = 1'b1;
      default:    ;
    endcase
  end

  assign isSample      = (sel == SEL_PCLO) || (sel == SEL_CTX) ||
                         (sel == SEL_VCTX) || (sel == SEL_PCHI);
  assign pwrBlocked    = !pwrOn || dblLock;
  assign sampleBlocked = pwrBlocked || osLocked;

  assign slverr = access && ((isSample && sampleBlocked) || (isOsLock && pwrBlocked));

  always_comb begin
    stb.capture  = access && !pwrite && (sel == SEL_PCLO) && !sampleBlocked && !coreProhibit;
    stb.wrCtrl   = access && pwrite && (sel == SEL_CTRL);
    stb.wrOsLock = access && pwrite && isOsLock && !pwrBlocked;
    stb.rdSel    = (access && !pwrite && !(isSample && sampleBlocked)) ? sel : SEL_NONE;
  end
endmodule

// File: rtl/pcsDbgDp.sv
module pcsDbgDp
  import pcsDbgPkg::*;
#(
  parameter int IMPL_LEVEL  = 3,
  parameter int OFFSET_MODE = 0,
  parameter int PC_W        = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] pwdata,
  input  logic [PC_W-1:0]   corePc,
  input  logic [DATA_W-1:0] coreCtxId,
  input  logic [VMID_W-1:0] coreVmid,
  input  logic              coreNs,
  input  logic              coreEl2,
  input  logic              coreEl3,
  input  logic              coreAa64,
  input  logic              coreProhibit,
  input  logic              corePwrGood,
  input  logic              coreDblLock,
  output logic [DATA_W-1:0] prdata,
  output logic              pwrOn,
  output logic              osLocked,
  output logic              pwrUpReq
);
  localparam int  HI_W     = PC_W - 32;
  localparam bit  HAS_CTX  = IMPL_LEVEL >= 2;
  localparam bit  HAS_VCTX = IMPL_LEVEL >= 3;
  localparam int  PAD_W    = DATA_W - 4 - VMID_W;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   ctrlPu;
  logic                   ctrlNpd;
  logic [DATA_W-1:0]      capCtx;
  logic [DATA_W-1:0]      capVctx;
  logic [HI_W-1:0]        capHi;
  logic [DATA_W-1:0]      vctxLive;

  assign vctxLive = {coreNs, coreEl2, coreEl3, coreAa64, {PAD_W{1'b0}}, coreVmid};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
    end else begin
      syncQ[0] <= corePwrGood;
      for (int k = 1; k < SYNC_STAGES; k++) syncQ[k] <= syncQ[k-1];
    end
  end
  assign pwrOn = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      osLocked <= 1'b1;
      ctrlPu   <= 1'b0;
      ctrlNpd  <= 1'b0;
      capHi    <= '0;
    end else begin
      if (stb.wrOsLock) osLocked <= |pwdata;
      if (stb.wrCtrl) begin
        ctrlPu <= pwdata[3];
        if (pwrOn) ctrlNpd <= pwdata[0];
      end
      if (stb.capture) capHi <= corePc[PC_W-1:32];
    end
  end

  generate
    if (HAS_CTX) begin : g_ctx
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)            capCtx <= '0;
        else if (stb.capture) capCtx <= coreCtxId;
      end
    end else begin : g_noCtx
      assign capCtx = '0;
    end
    if (HAS_VCTX) begin : g_vctx
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)            capVctx <= '0;
        else if (stb.capture) capVctx <= vctxLive;
      end
    end else begin : g_noVctx
      assign capVctx = '0;
    end
  endgenerate

  always_comb begin
    case (stb.rdSel)
      SEL_PCLO: prdata = coreProhibit ? '1 : corePc[31:0];
      SEL_CTX:  prdata = capCtx;
      SEL_VCTX: prdata = capVctx;
      SEL_PCHI: prdata = 32'(capHi);
      SEL_CTRL: prdata = {28'b0, ctrlPu, 2'b0, ctrlNpd};
      SEL_STAT: prdata = {25'b0, coreDblLock, 5'b0, pwrOn};
      SEL_ID1:  prdata = {28'b0, 4'(OFFSET_MODE)};
      SEL_ID:   prdata = {28'b0, 4'(IMPL_LEVEL)};
      default:  prdata = '0;
    endcase
  end

  assign pwrUpReq = ctrlPu;
endmodule

// File: rtl/pcsDbgTop.sv
module pcsDbgTop
  import pcsDbgPkg::*;
#(
  parameter int IMPL_LEVEL  = 3,
  parameter int OFFSET_MODE = 0,
  parameter int PC_W        = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pslverr,
  input  logic [PC_W-1:0]   corePc,
  input  logic [DATA_W-1:0] coreCtxId,
  input  logic [VMID_W-1:0] coreVmid,
  input  logic              coreNs,
  input  logic              coreEl2,
  input  logic              coreEl3,
  input  logic              coreAa64,
  input  logic              coreProhibit,
  input  logic              corePwrGood,
  input  logic              coreDblLock,
  output logic              pwrUpReq
);
  strobe_t stb;
  logic    pwrOn;
  logic    osLocked;

  pcsDbgCtrl u_ctrl (
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .pwrOn(pwrOn), .dblLock(coreDblLock), .osLocked(osLocked),
    .coreProhibit(coreProhibit), .stb(stb), .slverr(pslverr)
  );

  pcsDbgDp #(
    .IMPL_LEVEL(IMPL_LEVEL), .OFFSET_MODE(OFFSET_MODE),
    .PC_W(PC_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .pwdata(pwdata),
    .corePc(corePc), .coreCtxId(coreCtxId), .coreVmid(coreVmid),
    .coreNs(coreNs), .coreEl2(coreEl2), .coreEl3(coreEl3), .coreAa64(coreAa64),
    .coreProhibit(coreProhibit), .corePwrGood(corePwrGood), .coreDblLock(coreDblLock),
    .prdata(prdata), .pwrOn(pwrOn), .osLocked(osLocked), .pwrUpReq(pwrUpReq)
  );
endmodule

// File: rtl/pcsDbgChk.sv
module pcsDbgChk (
  input logic        clk,
  input logic        rstN,
  input logic        psel,
  input logic        penable,
  input logic        pwrite,
  input logic [11:0] paddr,
  input logic        wrBit3,
  input logic [31:0] prdata,
  input logic        pslverr,
  input logic        coreProhibit,
  input logic        pwrUpReq
);
  logic ctrlWrite;
  assign ctrlWrite = psel && penable && pwrite && (paddr == 12'h310);

  // R6
  ctrl_req_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWrite |=> (pwrUpReq == $past(wrBit3)));

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlWrite |=> $stable(pwrUpReq));

  // R4
  prohibit_ones_chk: assert property (@(posedge clk) disable iff (!rstN)
    (psel && penable && !pwrite && paddr == 12'h0A0 && coreProhibit && !pslverr)
      |-> (prdata == 32'hFFFF_FFFF));

  // R9
  err_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    pslverr |-> (psel && penable && prdata == 32'h0));

  // R9
  always_reach_chk: assert property (@(posedge clk) disable iff (!rstN)
    (psel && penable && (paddr == 12'h310 || paddr == 12'h314 ||
                         paddr == 12'hFC4 || paddr == 12'hFC8)) |-> !pslverr);
endmodule

bind pcsDbgTop pcsDbgChk u_chk (
  .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .wrBit3(pwdata[3]), .prdata(prdata), .pslverr(pslverr),
  .coreProhibit(coreProhibit), .pwrUpReq(pwrUpReq)
);

// File: tb/pcsDbgTop_bench.sv
module pcsDbgTop_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [63:0] corePc = '0;
  logic [31:0] coreCtxId = '0;
  logic [7:0]  coreVmid = '0;
  logic        coreNs = 0, coreEl2 = 0, coreEl3 = 0, coreAa64 = 0;
  logic        coreProhibit = 0, corePwrGood = 0, coreDblLock = 0;
  logic [31:0] prdata, prdataL1;
  logic        pslverr, pslverrL1, pwrUpReq, pwrUpReqL1;
  int          nChk = 0, nBad = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  pcsDbgTop u_pcsDbgTop (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pslverr(pslverr),
    .corePc(corePc), .coreCtxId(coreCtxId), .coreVmid(coreVmid),
    .coreNs(coreNs), .coreEl2(coreEl2), .coreEl3(coreEl3), .coreAa64(coreAa64),
    .coreProhibit(coreProhibit), .corePwrGood(corePwrGood),
    .coreDblLock(coreDblLock), .pwrUpReq(pwrUpReq)
  );

  pcsDbgTop #(.IMPL_LEVEL(1), .OFFSET_MODE(1)) u_pcsDbgTopL1 (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdataL1), .pslverr(pslverrL1),
    .corePc(corePc), .coreCtxId(coreCtxId), .coreVmid(coreVmid),
    .coreNs(coreNs), .coreEl2(coreEl2), .coreEl3(coreEl3), .coreAa64(coreAa64),
    .coreProhibit(coreProhibit), .corePwrGood(corePwrGood),
    .coreDblLock(coreDblLock), .pwrUpReq(pwrUpReqL1)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  logic [31:0] rdD, rdDL1;
  logic        rdE, rdEL1;

  task automatic rd(input logic [11:0] a);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1;
    #1; rdD = prdata; rdE = pslverr; rdDL1 = prdataL1; rdEL1 = pslverrL1;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  function automatic logic [31:0] vctxOf(input logic ns, e2, e3, w, input logic [7:0] vm);
    return (32'(ns) << 31) | (32'(e2) << 30) | (32'(e3) << 29) | (32'(w) << 28) | 32'(vm);
  endfunction

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] lastCtx;
    repeat (3) @(negedge clk);
    rstN = 1;

    // R1 reset state
    rd(12'h310); chk("R1 ctrl after reset", rdD, 32'h0);
    chk("R1 pwrUpReq after reset", {31'b0, pwrUpReq}, 32'h0);
    rd(12'h314); chk("R8 status powered down", rdD, 32'h0);
    rd(12'h0A0); chk("R9 pc read unpowered err", {31'b0, rdE}, 32'h1);
    chk("R9 pc read unpowered data", rdD, 32'h0);

    // R7 write while unpowered: bit3 taken, bit0 not
    wr(12'h310, 32'h9);
    rd(12'h310); chk("R7 npd ignored unpowered", rdD, 32'h8);
    chk("R6 pwrUpReq follows bit3", {31'b0, pwrUpReq}, 32'h1);

    // R8 synchronizer latency, status read held open
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = 12'h314;
    @(negedge clk); penable = 1; corePwrGood = 1;
    #1; chk("R8 status edge 0", prdata, 32'h0);
    @(negedge clk); #1; chk("R8 status edge 1", prdata, 32'h0);
    @(negedge clk); #1; chk("R8 status edge 2", prdata, 32'h1);
    @(negedge clk); psel = 0; penable = 0;

    // R2 OS lock still set from reset (R1)
    rd(12'h0A0); chk("R1 R2 oslock set err", {31'b0, rdE}, 32'h1);
    rd(12'h300); chk("R2 oslock reads zero", rdD, 32'h0);
    wr(12'h300, 32'h0);
    rd(12'h0A0); chk("R2 unlocked no err", {31'b0, rdE}, 32'h0);

    // R6 R7 control register
    wr(12'h310, 32'h9);
    rd(12'h310); chk("R7 npd set powered", rdD, 32'h9);
    wr(12'h310, 32'h0);
    rd(12'h310); chk("R6 ctrl cleared", rdD, 32'h0);
    chk("R6 pwrUpReq low", {31'b0, pwrUpReq}, 32'h0);
    wr(12'h310, 32'hFFFF_FFFF);
    rd(12'h310); chk("R6 only two bits", rdD, 32'h9);

    // R3 R5 R11 sweep across all four state flags
    for (int i = 0; i < 16; i++) begin
      logic [31:0] pcLo, pcHi, ctx, vctx;
      logic [3:0]  fl;
      fl   = 4'(i);
      pcLo = 32'h8000_0000 + 32'(i) * 32'h0000_0104;
      pcHi = 32'hA500_0000 ^ (32'(i) * 32'h0001_1111);
      ctx  = 32'hC0DE_0000 | 32'(i * 3);
      vctx = vctxOf(fl[0], fl[1], fl[2], fl[3], 8'(i * 17));
      corePc = {pcHi, pcLo}; coreCtxId = ctx; coreVmid = 8'(i * 17);
      coreNs = fl[0]; coreEl2 = fl[1]; coreEl3 = fl[2]; coreAa64 = fl[3];
      rd(12'h0A0);
      chk($sformatf("R3 pc low i=%0d", i), rdD, pcLo);
      chk($sformatf("R3 pc low L1 i=%0d", i), rdDL1, pcLo);
      corePc = ~corePc; coreCtxId = ~ctx; coreVmid = ~coreVmid;
      coreNs = ~coreNs; coreEl2 = ~coreEl2; coreEl3 = ~coreEl3; coreAa64 = ~coreAa64;
      rd(12'h0A4);
      chk($sformatf("R3 ctx captured i=%0d", i), rdD, ctx);
      chk($sformatf("R11 ctx absent L1 i=%0d", i), rdDL1, 32'h0);
      rd(12'h0A8);
      chk($sformatf("R5 vctx packed i=%0d", i), rdD, vctx);
      chk($sformatf("R11 vctx absent L1 i=%0d", i), rdDL1, 32'h0);
      rd(12'h0AC);
      chk($sformatf("R3 pc high captured i=%0d", i), rdD, pcHi);
      lastCtx = ctx;
    end

    // R4 prohibited read
    coreProhibit = 1; coreCtxId = 32'h1234_5678;
    rd(12'h0A0);
    chk("R4 prohibited ones", rdD, 32'hFFFF_FFFF);
    chk("R4 prohibited no err", {31'b0, rdE}, 32'h0);
    coreProhibit = 0;
    rd(12'h0A4); chk("R4 ctx not recaptured", rdD, lastCtx);

    // R10 identification and unmapped
    rd(12'hFC8); chk("R10 id level", rdD, 32'h3); chk("R10 id level L1", rdDL1, 32'h1);
    rd(12'hFC4); chk("R10 id1 offset", rdD, 32'h0); chk("R10 id1 offset L1", rdDL1, 32'h1);
    rd(12'h200); chk("R10 unmapped zero", rdD, 32'h0);
    chk("R10 unmapped no err", {31'b0, rdE}, 32'h0);

    // R8 R9 double lock
    coreDblLock = 1;
    rd(12'h314); chk("R8 status dbl lock", rdD, 32'h41);
    chk("R9 status no err", {31'b0, rdE}, 32'h0);
    rd(12'h0A8); chk("R9 dbl lock err", {31'b0, rdE}, 32'h1);
    chk("R9 dbl lock data", rdD, 32'h0);
    wr(12'h300, 32'h1);
    rd(12'h300); chk("R9 oslock err dbl", {31'b0, rdE}, 32'h1);
    coreDblLock = 0;
    rd(12'h0A0); chk("R9 oslock write ignored", {31'b0, rdE}, 32'h0);

    // R2 relock
    wr(12'h300, 32'h5);
    rd(12'h0AC); chk("R2 relocked err", {31'b0, rdE}, 32'h1);
    chk("R2 relocked data", rdD, 32'h0);
    wr(12'h300, 32'h0);

    // R7 power lost: npd keeps value
    wr(12'h310, 32'h9);
    corePwrGood = 0;
    repeat (3) @(negedge clk);
    wr(12'h310, 32'h8);
    rd(12'h310); chk("R7 npd kept unpowered", rdD, 32'h9);
    rd(12'h0A4); chk("R9 unpowered ctx err", {31'b0, rdE}, 32'h1);

    done = 1;
    summary();
    $finish;
  end
endmodule